// File: doc/BRIEF.md
# Dual Channel Timer/Counter

This block holds two identical 16-bit counting channels for a small microcontroller subsystem. Each channel keeps its count in a low byte and a high byte. It advances either once per machine cycle, which is four system clocks, or once per recognised falling edge on its own external count pin. A shared mode register sets, for each channel, the width of the count (13 or 16 bits), the count source and whether a gate pin may stall counting. A shared control register holds a run bit and a sticky overflow flag per channel. Each flag drives that channel's interrupt request output directly.

Software reaches all six registers through one byte-wide port: an address, a write strobe, write data and a combinational read-data output. The external count pins are sampled once per machine cycle. A high sample followed by a low sample counts as a falling edge, and the increment it causes lands one machine cycle later.

Top module: `dtu_timer_unit`

## Requirements
- R1: While reset is low, and after it is released, every register reads 0x00 and both interrupt outputs are low.
- R2: A machine cycle is four clocks. The first machine-cycle boundary falls on the fourth rising edge after reset release. In cycle-count function, an enabled channel advances by one at each boundary and at no other edge.
- R3: With the function bit set (mode bit 2 for channel 0, bit 6 for channel 1), the count pin is sampled at each boundary. A sample of 0 that follows a sample of 1 marks an edge, and the count advances at the next boundary, provided the channel is enabled at that boundary.
- R4: A channel advances only when its run bit (control bit 4 for channel 0, bit 6 for channel 1) is 1 and either its gate bit (mode bit 3 or bit 7) is 0 or its gate pin is 1.
- R5: Mode field value 0 (mode bits 1:0 for channel 0, bits 5:4 for channel 1) selects a 13-bit count. Low byte bits 4:0 increment, a carry out of bit 4 increments the high byte, and low byte bits 7:5 never change through counting.
- R6: In the 13-bit mode, the step from high=0xFF with low bits 4:0 = 0x1F wraps the count to zero and sets the channel's overflow flag.
- R7: Mode field value 1 selects a 16-bit count. The step from 0xFFFF wraps to 0x0000 and sets the overflow flag.
- R8: The overflow flags sit at control bit 5 (channel 0) and bit 7 (channel 1), and irq_o[c] equals flag c. A flag stays set until software writes 0 to it. An overflow in the same clock as that write leaves the flag set.
- R9: A write to a count byte in the same clock as an increment stores the written value in that byte. The other byte still takes its incremented value.
- R10: Mode field values 2 and 3 hold the count unchanged.
- R11: Addresses: 0 mode, 1 control, 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1. Addresses 6 and 7 read 0x00. Control bits 3:0 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | Gate pins, one per channel |
| irq_o | output | 2 | Overflow interrupt requests, one per channel |

## Verification
Two collisions matter here: a software write landing on a count byte at the same boundary the channel increments, and a software clear of the overflow flag landing in the same clock as a wrap. The bench provokes both by writing on every clock across a span that contains the boundary or the wrap, so at least one write coincides without relying on exact phase arithmetic. A behavioural model then judges each clock: the written byte must take the data, the other byte must still advance, and the flag must stay set.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 3;
  localparam int unsigned NCH    = 2;
  localparam int unsigned PHASES = 4;
  localparam int unsigned M0_LOW = 5;  // low-byte bits used in 13-bit mode

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_CTRL = 3'd1;
  localparam logic [AW-1:0] A_LO0  = 3'd2;
  localparam logic [AW-1:0] A_HI0  = 3'd3;

  // per-channel mode field: [1:0] width, [2] ext source, [3] gate
  localparam int unsigned MFIELD = 4;
  localparam int unsigned RUN0   = 4;  // flag at RUN0+1, next channel +2

  typedef enum logic [1:0] {
    MODE_13  = 2'd0,
    MODE_16  = 2'd1,
    MODE_HD2 = 2'd2,
    MODE_HD3 = 2'd3
  } cnt_mode_e;
endpackage

// File: rtl/dtu_tick.sv
module dtu_tick #(
  parameter int unsigned PHASES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ph_q <= '0;
    else if (ph_q == LAST) ph_q <= '0;
    else                   ph_q <= ph_q + 1'b1;
  end

  assign tick_o = (ph_q == LAST);
endmodule

// File: rtl/dtu_edge.sv
module dtu_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pin_i,
  output logic pend_o
);
  logic smp_q, pend_q;

  // pend_q holds a detected fall for one machine cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (tick_i) begin
      smp_q  <= pin_i;
      pend_q <= smp_q & ~pin_i;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel
  import dtu_pkg::*;
#(
  parameter int unsigned W   = DW,
  parameter int unsigned LOW = M0_LOW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         pin_i,
  input  logic         gate_pin_i,
  input  logic         run_i,
  input  logic         gate_en_i,
  input  logic         ext_i,
  input  logic [1:0]   mode_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_o
);
  logic [W-1:0]   lo_q, hi_q, lo_n, hi_n, lo_p1, hi_p1;
  logic [LOW-1:0] lo5_p1;
  logic           lo_c, hi_c, lo5_c, pend, inc;

  dtu_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pin_i  (pin_i),
    .pend_o (pend)
  );

  assign inc = tick_i & run_i & (~gate_en_i | gate_pin_i) & (~ext_i | pend);

  assign {lo_c, lo_p1}   = {1'b0, lo_q} + 1'b1;
  assign {hi_c, hi_p1}   = {1'b0, hi_q} + 1'b1;
  assign {lo5_c, lo5_p1} = {1'b0, lo_q[LOW-1:0]} + 1'b1;

  always_comb begin
    lo_n  = lo_q;
    hi_n  = hi_q;
    ovf_o = 1'b0;
    if (inc) begin
      case (cnt_mode_e'(mode_i))
        MODE_13: begin
          lo_n = {lo_q[W-1:LOW], lo5_p1};
          if (lo5_c) begin
            hi_n  = hi_p1;
            ovf_o = hi_c;
          end
        end
        MODE_16: begin
          lo_n = lo_p1;
          if (lo_c) begin
            hi_n  = hi_p1;
            ovf_o = hi_c;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= wr_lo_i ? wdata_i : lo_n;
      hi_q <= wr_hi_i ? wdata_i : hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/dtu_timer_unit.sv
module dtu_timer_unit
  import dtu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [NCH-1:0] cnt_pin_i,
  input  logic [NCH-1:0] gate_pin_i,
  output logic [NCH-1:0] irq_o
);
  logic                    tick;
  logic [DW-1:0]           mode_q;
  logic [NCH-1:0]          run_q, flag_q, ovf;
  logic [NCH-1:0][DW-1:0]  cnt_lo, cnt_hi;
  logic                    wr_ctrl;

  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);

  dtu_tick #(.PHASES(PHASES)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               mode_q <= '0;
    else if (wr_en_i && (addr_i == A_MODE))    mode_q <= wdata_i;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] ALO = AW'(A_LO0 + 2 * c);
    localparam logic [AW-1:0] AHI = AW'(A_HI0 + 2 * c);
    localparam int unsigned   MB  = MFIELD * c;
    localparam int unsigned   RB  = RUN0 + 2 * c;

    dtu_channel u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .pin_i      (cnt_pin_i[c]),
      .gate_pin_i (gate_pin_i[c]),
      .run_i      (run_q[c]),
      .gate_en_i  (mode_q[MB+3]),
      .ext_i      (mode_q[MB+2]),
      .mode_i     (mode_q[MB+:2]),
      .wr_lo_i    (wr_en_i && (addr_i == ALO)),
      .wr_hi_i    (wr_en_i && (addr_i == AHI)),
      .wdata_i    (wdata_i),
      .lo_o       (cnt_lo[c]),
      .hi_o       (cnt_hi[c]),
      .ovf_o      (ovf[c])
    );

    // overflow set beats a same-cycle software clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        run_q[c]  <= 1'b0;
        flag_q[c] <= 1'b0;
      end else begin
        if (wr_ctrl) run_q[c] <= wdata_i[RB];
        flag_q[c] <= (wr_ctrl ? wdata_i[RB+1] : flag_q[c]) | ovf[c];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      3'd0: rdata_o = mode_q;
      3'd1: rdata_o = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
      3'd2: rdata_o = cnt_lo[0];
      3'd3: rdata_o = cnt_hi[0];
      3'd4: rdata_o = cnt_lo[1];
      3'd5: rdata_o = cnt_hi[1];
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q;
endmodule

// File: rtl/dtu_checker.sv
module dtu_checker
  import dtu_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [AW-1:0]          addr_i,
  input logic [DW-1:0]          wdata_i,
  input logic                   tick,
  input logic [NCH-1:0]         run_q,
  input logic [NCH-1:0]         flag_q,
  input logic [DW-1:0]          mode_q,
  input logic [DW-1:0]          lo0,
  input logic [DW-1:0]          hi0
);
  logic wr_lo0, wr_c0, wr_ctrl;
  assign wr_lo0  = wr_en_i && (addr_i == A_LO0);
  assign wr_c0   = wr_lo0 || (wr_en_i && (addr_i == A_HI0));
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);

  AST_NO_STEP_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !wr_c0) |=> $stable({hi0, lo0})); // R2

  AST_NO_STEP_NOT_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q[0] && !wr_c0) |=> $stable({hi0, lo0})); // R4

  AST_M0_TOP_BITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1:0] == 2'b00 && !wr_lo0) |=> (lo0[7:5] == $past(lo0[7:5]))); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !wr_ctrl) |=> flag_q[0]); // R8

  AST_LO_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo0 |=> (lo0 == $past(wdata_i))); // R9

  AST_HOLD_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !wr_c0) |=> $stable({hi0, lo0})); // R10

  AST_CH1_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[1] && !wr_ctrl) |=> flag_q[1]); // R8
endmodule

bind dtu_timer_unit dtu_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tick    (tick),
  .run_q   (run_q),
  .flag_q  (flag_q),
  .mode_q  (mode_q),
  .lo0     (cnt_lo[0]),
  .hi0     (cnt_hi[0])
);

// File: tb/dtu_timer_unit_tb.sv
module dtu_timer_unit_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [1:0] cnt_pin_i = 2'b00;
  logic [1:0] gate_pin_i = 2'b00;
  logic [1:0] irq_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference state
  int m_ph = 0;
  int m_mode = 0;
  int m_run[2] = '{0, 0};
  int m_flag[2] = '{0, 0};
  int m_lo[2] = '{0, 0};
  int m_hi[2] = '{0, 0};
  int m_smp[2] = '{0, 0};
  int m_pend[2] = '{0, 0};

  always #4 clk_i = ~clk_i;  // 125 MHz

  dtu_timer_unit u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cnt_pin_i  (cnt_pin_i),
    .gate_pin_i (gate_pin_i),
    .irq_o      (irq_o)
  );

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ph = 0; m_mode = 0;
      for (int c = 0; c < 2; c++) begin
        m_run[c] = 0; m_flag[c] = 0; m_lo[c] = 0; m_hi[c] = 0;
        m_smp[c] = 0; m_pend[c] = 0;
      end
    end else begin
      int tk;
      int nlo[2];
      int nhi[2];
      int ovf[2];
      tk = (m_ph == 3);
      m_ph = (m_ph + 1) % 4;
      for (int c = 0; c < 2; c++) begin
        int f, en, step, v;
        f = (m_mode >> (4 * c)) & 15;
        en = m_run[c] && (((f >> 3) & 1) == 0 || gate_pin_i[c]);
        step = tk && en && ((((f >> 2) & 1) == 0) || m_pend[c]);
        nlo[c] = m_lo[c]; nhi[c] = m_hi[c]; ovf[c] = 0;
        if (step && (f & 3) == 0) begin
          v = m_hi[c] * 32 + (m_lo[c] & 31) + 1;
          ovf[c] = (v == 8192);
          v = v % 8192;
          nlo[c] = (m_lo[c] & 224) | (v & 31);
          nhi[c] = v / 32;
        end else if (step && (f & 3) == 1) begin
          v = m_hi[c] * 256 + m_lo[c] + 1;
          ovf[c] = (v == 65536);
          v = v % 65536;
          nlo[c] = v % 256;
          nhi[c] = v / 256;
        end
        if (tk) begin
          m_pend[c] = m_smp[c] && !cnt_pin_i[c];
          m_smp[c] = cnt_pin_i[c];
        end
      end
      for (int c = 0; c < 2; c++) begin
        if (wr_en_i && addr_i == 3'(2 + 2 * c)) nlo[c] = wdata_i;
        if (wr_en_i && addr_i == 3'(3 + 2 * c)) nhi[c] = wdata_i;
        m_lo[c] = nlo[c]; m_hi[c] = nhi[c];
        if (wr_en_i && addr_i == 3'd1) begin
          m_run[c] = wdata_i[4 + 2 * c];
          m_flag[c] = wdata_i[5 + 2 * c];
        end
        if (ovf[c]) m_flag[c] = 1;
      end
      if (wr_en_i && addr_i == 3'd0) m_mode = wdata_i;
    end
  end

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_mode;
      1: return m_flag[1] * 128 + m_run[1] * 64 + m_flag[0] * 32 + m_run[0] * 16;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  task automatic check_now();
    int er, ei;
    er = exp_rd(addr_i);
    ei = m_flag[1] * 2 + m_flag[0];
    checks++;
    if (int'(rdata_o) != er) begin
      errors++;
      $display("FAIL %s rdata addr=%0d actual=%02h expected=%02h t=%0t", cur_req, addr_i, rdata_o, er, $time);
    end
    checks++;
    if (int'(irq_o) != ei) begin
      errors++;
      $display("FAIL %s irq actual=%0d expected=%0d t=%0t", cur_req, irq_o, ei, $time);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    check_now();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic watch(input logic [2:0] a, input int n);
    addr_i = a;
    repeat (n) step();
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state, also during reset
    cur_req = "R1";
    for (int a = 0; a < 8; a++) begin addr_i = 3'(a); step(); end
    rst_ni = 1'b1;
    for (int a = 0; a < 8; a++) begin addr_i = 3'(a); step(); end

    // R11: map, unused addresses, ignored control bits
    cur_req = "R11";
    wr(3'd1, 8'h0F);
    watch(3'd1, 2);
    watch(3'd6, 1);
    watch(3'd7, 1);

    // R2: both channels 16-bit cycle count
    cur_req = "R2";
    wr(3'd0, 8'h11);
    wr(3'd1, 8'h50);
    watch(3'd2, 20);
    watch(3'd4, 12);

    // R9: writes on every clock across boundaries
    cur_req = "R9";
    wr(3'd2, 8'hFF);
    for (int i = 0; i < 6; i++) wr(3'd3, 8'(8'h40 + i));
    watch(3'd2, 4);
    for (int i = 0; i < 6; i++) wr(3'd2, 8'(8'hFE));
    watch(3'd3, 8);

    // R7: 16-bit wrap
    cur_req = "R7";
    wr(3'd2, 8'hFD);
    wr(3'd3, 8'hFF);
    watch(3'd1, 16);
    watch(3'd3, 4);

    // R8: clear flag; clear on every clock across a wrap
    cur_req = "R8";
    wr(3'd1, 8'h50);
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'hFF);
    for (int i = 0; i < 10; i++) wr(3'd1, 8'h50);
    watch(3'd1, 8);
    wr(3'd1, 8'h50);
    watch(3'd1, 4);

    // R5: 13-bit carry from bit 4, top bits fixed
    cur_req = "R5";
    wr(3'd0, 8'h10);
    wr(3'd2, 8'hFD);
    wr(3'd3, 8'h12);
    watch(3'd2, 16);
    watch(3'd3, 8);

    // R6: 13-bit wrap sets flag
    cur_req = "R6";
    wr(3'd2, 8'hBD);
    wr(3'd3, 8'hFF);
    watch(3'd1, 12);
    watch(3'd2, 4);
    watch(3'd3, 4);
    wr(3'd1, 8'h50);

    // R4: run bit and gate
    cur_req = "R4";
    wr(3'd0, 8'h19);
    gate_pin_i = 2'b00;
    watch(3'd2, 12);
    gate_pin_i = 2'b01;
    watch(3'd2, 12);
    wr(3'd1, 8'h40);
    watch(3'd2, 12);
    wr(3'd0, 8'h11);
    watch(3'd2, 8);
    wr(3'd1, 8'h50);

    // R3: channel 1 counts pin falls
    cur_req = "R3";
    wr(3'd0, 8'h51);
    addr_i = 3'd4;
    for (int i = 0; i < 6; i++) begin
      cnt_pin_i[1] = 1'b1; watch(3'd4, 8);
      cnt_pin_i[1] = 1'b0; watch(3'd4, 8);
    end
    for (int i = 0; i < 12; i++) begin
      cnt_pin_i[1] = ~cnt_pin_i[1]; watch(3'd4, 2);
    end
    for (int i = 0; i < 4; i++) begin
      cnt_pin_i[1] = 1'b1; watch(3'd4, 4);
      cnt_pin_i[1] = 1'b0; watch(3'd4, 4);
    end
    cnt_pin_i[1] = 1'b1; watch(3'd4, 4);
    wr(3'd1, 8'h10);
    cnt_pin_i[1] = 1'b0; watch(3'd4, 16);

    // R10: held modes
    cur_req = "R10";
    wr(3'd1, 8'h50);
    wr(3'd0, 8'h02);
    watch(3'd2, 12);
    wr(3'd0, 8'h03);
    watch(3'd3, 12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule